// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is a slave-side protocol engine for a byte-wide memory reached over a two-wire serial bus (I2C style). A fast system clock oversamples the serial clock and data lines. The engine finds bus Start and Stop conditions and shifts bytes in and out with the most significant bit first. It compares the select byte against a fixed type code and three strap inputs. It then takes a two-byte memory address and answers each accepted byte by pulling the data line low through an active-low output enable.

Behind the bus logic is an internal byte array, reached through a single address pointer that steps forward after every byte moved. A master can write bytes one after another, read starting from wherever the pointer was left, or load the pointer with a write-mode select and then switch to read with a repeated Start. A write-control input blocks all array writes. While it is high, the engine still acknowledges the select and address bytes but withholds the acknowledge on every data byte.

Array depth is set by `MEM_AW` address bits; the default of 11 keeps elaboration small, and 15 gives the full 32K x 8 array. The system clock must run at least eight times faster than the serial clock.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high (Start) begins a new select byte from any state, including as a repeated Start; a rising data line while the clock is high (Stop) returns the engine to idle with the data line released. Bytes clocked without a preceding Start are never acknowledged.
- R2: The select byte is sent MSB first as type code 1010 in bits 7..4, the strap value in bits 3..1 (bit 3 = strap[2]), and a direction bit in bit 0 (1 = read, 0 = write). When the type code and strap bits both match, the engine pulls the data line low during the 9th clock.
- R3: On a select byte whose type code or strap bits differ, the engine gives no acknowledge and ignores every later byte until the next Start.
- R4: After a write-mode select, the next two bytes are the address, high byte first. Only the low `MEM_AW` bits of the 16-bit value are kept, and both address bytes are acknowledged.
- R5: Each data byte after the address is stored at the pointer and acknowledged, and the pointer then advances by one.
- R6: While `wr_lock` is high, select and address bytes are still acknowledged, but data bytes are not, and the array keeps its old contents.
- R7: A random read (write-mode select, address, repeated Start, read-mode select) returns the byte at the loaded address, MSB first.
- R8: During a read, a master acknowledge makes the engine send the byte at the next address. Both reading and writing wrap from the top address to 0.
- R9: A read-mode select given straight after Start returns the byte at the pointer left behind by the previous transfer.
- R10: A master NoAck after a read byte ends the read. The engine keeps the data line released until the next Start.
- R11: The data-line output enable changes only while the serial clock is low, so a bit driven by the slave never looks like a Start or a Stop.
- R12: After reset, the data line is released and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND value) |
| sda_oe | output | 1 | High pulls the data line low; low releases it |
| strap | input | 3 | Board-set select bits compared with select byte bits 3..1 |
| wr_lock | input | 1 | High blocks array writes and withholds data-byte acknowledges |

## Verification
Each bus pin passes through two synchronizer flops before the edge logic sees it, so a serial clock edge reaches the engine two to three system cycles after the pin changes. The output enable moves one cycle after that, and an array write lands one cycle later again. The bench moves the serial clock only every ten system cycles. It samples the data line a full quarter-period after raising the clock, well after the output enable has settled from the preceding falling edge, and it checks stored contents only by reading them back over the bus. A monitor compares the output enable on every falling system clock edge and counts any change seen while the serial clock is high.

// File: rtl/i2cm_pkg.sv
// Shared definitions for the two-wire memory slave.
// Assumes: a single byte-wide array behind a single address pointer.
package i2cm_pkg;

    // Phase of the bus transaction the engine is in.
    typedef enum logic [2:0] {
        PH_IDLE,   // ignoring the bus until a Start
        PH_SEL,    // receiving the select byte
        PH_ADRH,   // receiving the address high byte
        PH_ADRL,   // receiving the address low byte
        PH_WDAT,   // receiving data bytes to store
        PH_RDAT    // sending data bytes to the master
    } phase_t;

    // Fixed type code expected in select byte bits 7..4.
    localparam logic [3:0] SEL_TYPE = 4'b1010;

    // Bit-count values that mark the ends of a byte slot.
    localparam logic [3:0] CNT_BYTE = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;

endpackage

// File: rtl/i2cm_sync.sv
// Brings the serial clock and data pins into the system clock domain and
// derives clock edges plus Start and Stop events from them.
// Assumes: STAGES >= 2; the bus idles high, so reset loads ones.
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] pin_raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Synchronizer chain plus one delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], pin_raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign cur[g] = chain[STAGES-1];
        assign prv[g] = last;
    end

    assign scl_s     = cur[1];
    assign sda_s     = cur[0];
    assign scl_rise  = cur[1] & ~prv[1];
    assign scl_fall  = ~cur[1] & prv[1];
    assign start_det = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign stop_det  = cur[1] & prv[1] & ~prv[0] & cur[0];

endmodule

// File: rtl/i2cm_array.sv
// Byte array with one registered write port and a combinational read port.
// Assumes: write and read addresses are already limited to AW bits.
module i2cm_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one byte when the engine strobes a write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2cm_engine.sv
// Protocol engine: counts bit slots, assembles and serializes bytes, decides
// acknowledges, and owns the auto-incrementing address pointer.
// Assumes: events arrive from i2cm_sync one per system clock; AW > 8.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [2:0]    strap,
    input  logic          wr_lock,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          mem_we,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);

    localparam int              HI_W     = AW - 8;
    localparam logic [AW-1:0]   PTR_STEP = AW'(1);

    phase_t            phase;
    phase_t            after_ack;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        txbyte;
    logic [HI_W-1:0]   adr_hi;
    logic [AW-1:0]     ptr;
    logic              sel_hit;

    assign rd_addr = ptr;
    assign sel_hit = (shreg[7:4] == SEL_TYPE) && (shreg[3:1] == strap);

    // Bus sequencing: phases, bit slots, acknowledge drive and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            after_ack <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txbyte    <= '0;
            adr_hi    <= '0;
            ptr       <= '0;
            mem_we    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            sda_oe    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (start_det) begin
                phase  <= PH_SEL;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (phase != PH_RDAT && bitcnt < CNT_BYTE) begin
                        shreg <= {shreg[6:0], sda_s};
                    end
                    if (phase == PH_RDAT && bitcnt == CNT_BYTE && sda_s) begin
                        phase <= PH_IDLE;   // master NoAck ends the read
                    end
                    if (bitcnt != CNT_ACK) begin
                        bitcnt <= bitcnt + 4'd1;
                    end
                end else if (scl_fall) begin
                    if (phase == PH_RDAT) begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                            sda_oe <= ~txbyte[3'(4'd7 - bitcnt)];
                        end else if (bitcnt == CNT_BYTE) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + PTR_STEP;
                        end else if (bitcnt == CNT_ACK) begin
                            txbyte <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bitcnt <= '0;
                        end
                    end else if (bitcnt == CNT_BYTE) begin
                        case (phase)
                            PH_SEL: begin
                                if (sel_hit) begin
                                    sda_oe    <= 1'b1;
                                    after_ack <= shreg[0] ? PH_RDAT : PH_ADRH;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_ADRH: begin
                                sda_oe    <= 1'b1;
                                adr_hi    <= shreg[HI_W-1:0];
                                after_ack <= PH_ADRL;
                            end
                            PH_ADRL: begin
                                sda_oe    <= 1'b1;
                                ptr       <= {adr_hi, shreg};
                                after_ack <= PH_WDAT;
                            end
                            PH_WDAT: begin
                                after_ack <= PH_WDAT;
                                if (!wr_lock) begin
                                    sda_oe  <= 1'b1;
                                    mem_we  <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + PTR_STEP;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (bitcnt == CNT_ACK) begin
                        bitcnt <= '0;
                        phase  <= after_ack;
                        if (after_ack == PH_RDAT) begin
                            txbyte <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_mem_slave.sv
// Top level: pin synchronizer, protocol engine and byte array.
// Assumes: clk is at least 8x the serial clock; sda_i is the wired-AND bus
// value, which already includes this block's own pull-down.
module i2c_mem_slave #(
    parameter int MEM_AW      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap,
    input  logic       wr_lock
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              mem_we;
    logic [MEM_AW-1:0] wr_addr;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_engine #(.AW(MEM_AW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap),
        .wr_lock   (wr_lock),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .mem_we    (mem_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2cm_array #(.AW(MEM_AW), .DW(8)) u_arr (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2cm_checker.sv
// Property checker for i2c_mem_slave, attached by the bind below.
// Assumes: the names bound here exist inside the top module.
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic start_det,
    input logic stop_det,
    input logic mem_we,
    input logic wr_lock
);

    // R11: the slave starts pulling low only while the clock is low.
    a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R11: a release happens with the clock low unless a Start or Stop forced it.
    a_r11_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_s || $past(start_det) || $past(stop_det)));

    // R1: the data line is free in the cycle after a Stop.
    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R1: the data line is free in the cycle after a Start.
    a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R6: no array write follows a cycle with the write lock high.
    a_r6_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wr_lock));

    // R5: stores happen in the clock-low half of the bit slot.
    a_r5_store_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !scl_s);

endmodule

bind i2c_mem_slave i2cm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_we    (mem_we),
    .wr_lock   (wr_lock)
);

// File: tb/sim_i2c_mem_slave.sv
`timescale 1ns/1ps
// Directed bench: a bus master model drives the serial lines, and each
// scenario task checks its own results through the bus.
module sim_i2c_mem_slave;

    localparam int         Q     = 10;       // system cycles per quarter bit
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = 8'hAA;    // 1010_101_0
    localparam logic [7:0] SEL_R = 8'hAB;    // 1010_101_1

    logic clk     = 1'b0;
    logic rst_n   = 1'b0;
    logic scl_m   = 1'b1;
    logic sda_m   = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int r11_viol = 0;
    bit finished = 1'b0;
    logic oe_prev = 1'b0;

    i2c_mem_slave #(.MEM_AW(11), .SYNC_STAGES(2)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .strap   (STRAP),
        .wr_lock (wr_lock)
    );

    always #2.5 clk = ~clk;

    // R11 monitor: the output enable must not move while the clock is high.
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== oe_prev)) r11_viol++;
        oe_prev = sda_oe;
    end

    task automatic qwait(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(2);
            scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = sda_bus;
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qwait();
            scl_m = 1'b1; qwait();
            b[i] = sda_bus;
            qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = !mack; qwait();
        scl_m = 1'b1; qwait(2);
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    // Address phase after a write-mode select; checks all three acknowledges.
    task automatic set_addr(input logic [15:0] a, input string tag);
        logic ack;
        bus_start();
        send_byte(SEL_W, ack);    chk({tag, " select ack"}, {7'd0, ack}, 8'd0);
        send_byte(a[15:8], ack);  chk({tag, " addr hi ack"}, {7'd0, ack}, 8'd0);
        send_byte(a[7:0], ack);   chk({tag, " addr lo ack"}, {7'd0, ack}, 8'd0);
    endtask

    // Random read of n bytes from a, compared to exp, ending with NoAck.
    task automatic read_at(input logic [15:0] a, input logic [7:0] exp [4], input int n,
                           input string tag);
        logic ack;
        logic [7:0] d;
        set_addr(a, tag);
        bus_start();
        send_byte(SEL_R, ack);    chk({tag, " read select ack"}, {7'd0, ack}, 8'd0);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            chk({tag, " read data"}, d, exp[k]);
        end
        chk("R10 released after NoAck", {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    task automatic t_reset();
        logic ack;
        chk("R12 released after reset", {7'd0, sda_oe}, 8'd0);
        send_byte(SEL_W, ack);    // no Start before it
        chk("R1 no ack without Start", {7'd0, ack}, 8'd1);
    endtask

    task automatic t_byte_write();
        logic ack;
        set_addr(16'h0123, "R2 R4");
        for (int k = 0; k < 5; k++) begin
            send_byte(8'h11 * (k + 1), ack);
            chk("R5 data ack", {7'd0, ack}, 8'd0);
        end
        bus_stop();
        chk("R1 released after Stop", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic t_random_seq_read();
        logic [7:0] e [4] = '{8'h22, 8'h33, 8'h44, 8'h00};
        read_at(16'h0124, e, 3, "R7 R8");
    endtask

    task automatic t_current_read();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(SEL_R, ack);    chk("R9 select ack", {7'd0, ack}, 8'd0);
        recv_byte(d, 1'b0);
        chk("R9 current address data", d, 8'h55);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        send_byte(8'hA8, ack);    chk("R3 strap mismatch no ack", {7'd0, ack}, 8'd1);
        send_byte(8'h00, ack);    chk("R3 later byte ignored", {7'd0, ack}, 8'd1);
        bus_stop();
        bus_start();
        send_byte(8'hBA, ack);    chk("R3 type mismatch no ack", {7'd0, ack}, 8'd1);
        bus_stop();
    endtask

    task automatic t_lock();
        logic ack;
        logic [7:0] e [4] = '{8'h11, 8'h22, 8'h00, 8'h00};
        wr_lock = 1'b1;
        set_addr(16'h0123, "R6");
        send_byte(8'hEE, ack);    chk("R6 data not acked", {7'd0, ack}, 8'd1);
        send_byte(8'hEF, ack);    chk("R6 second data not acked", {7'd0, ack}, 8'd1);
        bus_stop();
        wr_lock = 1'b0;
        read_at(16'h0123, e, 2, "R6 contents kept");
    endtask

    task automatic t_high_bits();
        logic ack;
        logic [7:0] e [4] = '{8'h5A, 8'h00, 8'h00, 8'h00};
        set_addr(16'hF805, "R4");
        send_byte(8'h5A, ack);    chk("R4 data ack", {7'd0, ack}, 8'd0);
        bus_stop();
        read_at(16'h0005, e, 1, "R4 upper bits dropped");
    endtask

    task automatic t_wrap();
        logic ack;
        logic [7:0] e [4] = '{8'hA1, 8'hB2, 8'h00, 8'h00};
        set_addr(16'h07FF, "R8");
        send_byte(8'hA1, ack);    chk("R8 top data ack", {7'd0, ack}, 8'd0);
        send_byte(8'hB2, ack);    chk("R8 wrapped data ack", {7'd0, ack}, 8'd0);
        bus_stop();
        read_at(16'h07FF, e, 2, "R8 wrap to 0");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        bus_stop();
        t_byte_write();
        t_random_seq_read();
        t_current_read();
        t_mismatch();
        t_lock();
        t_high_bits();
        t_wrap();
        chk("R11 no enable change with clock high", 8'(r11_viol), 8'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule